// File: doc/BRIEF.md
# Indirect Register Mailbox Port

This block lets a byte-wide host reach an internal register space without mapping each register into the host's address range. The host sees three byte locations: a data port, a combined status/command port, and an interrupt-control byte. To reach a register, the host writes an opcode to the command port, then sends the register index and, for a store, the value through the data port. For a load, the register contents come back on the data port once the block signals that its output holds a fresh byte.

Every byte the host writes lands in a one-byte input holder and raises an input-busy flag. The flag drops once an internal sequencer has consumed the byte, a fixed number of cycles later. The host must see input-busy low before each byte it writes, and output-ready high before it reads a result. The sequencer drives the register space through a single-cycle read strobe or write strobe, carrying an index and a write value. On a read, the register space returns the data combinationally.

Top module: `ira_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00, `irq` is low, and neither `reg_rd` nor `reg_wr` is asserted.
- R2: A host write accepted at either the data port (offset 0x0) or the command port (offset 0x4) sets input-busy (status bit 1) from the next cycle. Input-busy clears exactly CONSUME_CYC clock edges after the write edge.
- R3: A host write that arrives while input-busy is set is dropped. It changes neither the held byte, nor the command flag, nor the sequence in progress.
- R4: Opcode 0x80 followed by an index byte produces a one-cycle `reg_rd` carrying that index. The data is captured, and output-ready (status bit 0) rises on the next edge, with the value shown on the data port.
- R5: A host read of the data port clears output-ready at that clock edge.
- R6: Opcode 0x81 followed by an index byte and then a value byte produces exactly one one-cycle `reg_wr` carrying that index and value.
- R7: An opcode byte that arrives in the middle of a sequence abandons the unfinished sequence, and a new sequence starts from that opcode.
- R8: Status bit 3 is set by an accepted command-port write and cleared by an accepted data-port write.
- R9: Data-port bytes sent while no sequence is open, and any opcode other than 0x80 or 0x81, produce no register strobe. An unknown opcode also leaves no sequence open.
- R10: The byte at offset 0x8 reads back what was last written to it. While its bit 0 is set, `irq` equals output-ready; while bit 0 is clear, `irq` stays low.
- R11: `reg_rd` and `reg_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe (with host_sel) |
| host_rd | input | 1 | Host read strobe (with host_sel); side effects only |
| host_addr | input | ADDR_W | Host byte offset; bits [3:2] choose data, status/command or interrupt control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the addressed location, valid combinationally from host_addr |
| irq | output | 1 | Output-ready interrupt, gated by interrupt-control bit 0 |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_idx | output | IDX_W | Register index for the strobes |
| reg_wdata | output | 8 | Value for reg_wr |
| reg_rdata | input | 8 | Register value returned during reg_rd |

## Verification
Each result lands a fixed number of edges after the write edge of the byte that causes it. Input-busy reads high at the falling edge right after the write and low at the CONSUME_CYC-th falling edge. A register strobe is high at that same falling edge, and output-ready follows one falling edge later. The bench drives every host access at a falling edge and peeks at the combinational read data without issuing a read strobe. It therefore samples at exactly those falling edges, and it counts strobes at each falling edge to prove that dropped or ignored bytes caused nothing.

// File: rtl/ira_pkg.sv
package ira_pkg;

  localparam logic [7:0] OP_LOAD  = 8'h80;
  localparam logic [7:0] OP_STORE = 8'h81;

  localparam logic [1:0] WIN_DATA = 2'd0;
  localparam logic [1:0] WIN_CTRL = 2'd1;
  localparam logic [1:0] WIN_INTC = 2'd2;

  localparam int ST_OUT_RDY = 0;
  localparam int ST_IN_BUSY = 1;
  localparam int ST_WAS_OP  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LD_IDX,
    SQ_ST_IDX,
    SQ_ST_VAL
  } seq_state_e;

endpackage

// File: rtl/ira_host_if.sv
module ira_host_if
  import ira_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              in_busy,
  input  logic              out_rdy,
  input  logic              was_op,
  input  logic [7:0]        out_byte,
  output logic              put_data,
  output logic              put_op,
  output logic              take_data,
  output logic              irq,
  output logic [7:0]        host_rdata
);

  logic [1:0] win;
  logic [7:0] intc_q, intc_n;
  logic       intc_en;
  logic [7:0] status_byte;

  assign win = host_addr[3:2];

  assign put_data  = host_sel && host_wr && (win == WIN_DATA);
  assign put_op    = host_sel && host_wr && (win == WIN_CTRL);
  assign take_data = host_sel && host_rd && (win == WIN_DATA);
  assign intc_en   = host_sel && host_wr && (win == WIN_INTC);

  always_comb begin
    intc_n = intc_q;
    if (intc_en) intc_n = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intc_q <= '0;
    else        intc_q <= intc_n;
  end

  always_comb begin
    status_byte = '0;
    status_byte[ST_OUT_RDY] = out_rdy;
    status_byte[ST_IN_BUSY] = in_busy;
    status_byte[ST_WAS_OP]  = was_op;
  end

  always_comb begin
    case (win)
      WIN_DATA: host_rdata = out_byte;
      WIN_CTRL: host_rdata = status_byte;
      WIN_INTC: host_rdata = intc_q;
      default:  host_rdata = '0;
    endcase
  end

  assign irq = intc_q[0] && out_rdy;

  // R10: an interrupt-control write is visible on the next cycle
  p_intc_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    intc_en |=> (intc_q == $past(host_wdata)));

endmodule

// File: rtl/ira_inbuf.sv
module ira_inbuf #(
  parameter int CONSUME_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       put_data,
  input  logic       put_op,
  input  logic [7:0] wdata,
  output logic       in_busy,
  output logic [7:0] held_byte,
  output logic       held_is_op,
  output logic       consume
);

  localparam int CNT_W = (CONSUME_CYC < 2) ? 1 : $clog2(CONSUME_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONSUME_CYC - 1);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       byte_q, byte_n;
  logic             op_q, op_n;
  logic             put_any;
  logic             accept;

  assign put_any = put_data || put_op;
  assign accept  = put_any && !busy_q;
  assign consume = busy_q && (cnt_q == CNT_LAST);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    byte_n = byte_q;
    op_n   = op_q;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      byte_n = wdata;
      op_n   = put_op;
    end else if (consume) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      byte_q <= '0;
      op_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      byte_q <= byte_n;
      op_q   <= op_n;
    end
  end

  assign in_busy    = busy_q;
  assign held_byte  = byte_q;
  assign held_is_op = op_q;

  // R2: a write taken while idle raises busy and holds that byte
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (put_any && !busy_q) |=> (busy_q && byte_q == $past(wdata)));

  // R2: consuming the byte drops busy
  p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !busy_q);

  // R3: a write while busy leaves the held byte and its kind untouched
  p_drop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (put_any && busy_q) |=> ($stable(byte_q) && $stable(op_q)));

endmodule

// File: rtl/ira_seq.sv
module ira_seq
  import ira_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             consume,
  input  logic [7:0]       held_byte,
  input  logic             held_is_op,
  input  logic             take_data,
  input  logic [7:0]       reg_rdata,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic [IDX_W-1:0] reg_idx,
  output logic [7:0]       reg_wdata,
  output logic             out_rdy,
  output logic [7:0]       out_byte
);

  seq_state_e       st_q, st_n;
  logic             rd_q, rd_n;
  logic             wr_q, wr_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [7:0]       wdat_q, wdat_n;
  logic             rdy_q, rdy_n;
  logic [7:0]       obuf_q, obuf_n;
  logic             obuf_en;
  logic             op_known;

  assign op_known = (held_byte == OP_LOAD) || (held_byte == OP_STORE);

  always_comb begin
    st_n   = st_q;
    rd_n   = 1'b0;
    wr_n   = 1'b0;
    idx_n  = idx_q;
    wdat_n = wdat_q;
    if (consume) begin
      if (held_is_op) begin
        if (held_byte == OP_LOAD)       st_n = SQ_LD_IDX;
        else if (held_byte == OP_STORE) st_n = SQ_ST_IDX;
        else                            st_n = SQ_IDLE;
      end else begin
        case (st_q)
          SQ_LD_IDX: begin
            rd_n  = 1'b1;
            idx_n = held_byte[IDX_W-1:0];
            st_n  = SQ_IDLE;
          end
          SQ_ST_IDX: begin
            idx_n = held_byte[IDX_W-1:0];
            st_n  = SQ_ST_VAL;
          end
          SQ_ST_VAL: begin
            wr_n   = 1'b1;
            wdat_n = held_byte;
            st_n   = SQ_IDLE;
          end
          default: st_n = SQ_IDLE;
        endcase
      end
    end
  end

  assign obuf_en = rd_q;

  always_comb begin
    rdy_n  = rdy_q;
    obuf_n = obuf_q;
    if (obuf_en) begin
      rdy_n  = 1'b1;
      obuf_n = reg_rdata;
    end else if (take_data) begin
      rdy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      wdat_q <= '0;
      rdy_q  <= 1'b0;
      obuf_q <= '0;
    end else begin
      st_q   <= st_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      idx_q  <= idx_n;
      wdat_q <= wdat_n;
      rdy_q  <= rdy_n;
      obuf_q <= obuf_n;
    end
  end

  assign reg_rd    = rd_q;
  assign reg_wr    = wr_q;
  assign reg_idx   = idx_q;
  assign reg_wdata = wdat_q;
  assign out_rdy   = rdy_q;
  assign out_byte  = obuf_q;

  // R4: a read strobe lasts one cycle and leaves output-ready set
  p_load_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> (rdy_q && !rd_q));

  // R5: a data-port read with no capture pending empties the output
  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_data && !rd_q) |=> !rdy_q);

  // R6: a write strobe lasts one cycle
  p_store_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R7: an opcode consumed mid-sequence restarts from that opcode
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && held_is_op && held_byte == OP_LOAD) |=> (st_q == SQ_LD_IDX));

  // R9: an unknown opcode leaves no sequence open
  p_unknown_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && held_is_op && !op_known) |=> (st_q == SQ_IDLE));

  // R11: the two strobes never overlap
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));

endmodule

// File: rtl/ira_port.sv
module ira_port #(
  parameter int ADDR_W      = 4,
  parameter int IDX_W       = 8,
  parameter int CONSUME_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic       put_data, put_op, take_data;
  logic       in_busy, held_is_op, consume;
  logic [7:0] held_byte;
  logic       out_rdy;
  logic [7:0] out_byte;

  ira_host_if #(.ADDR_W(ADDR_W)) u_host_if (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .in_busy    (in_busy),
    .out_rdy    (out_rdy),
    .was_op     (held_is_op),
    .out_byte   (out_byte),
    .put_data   (put_data),
    .put_op     (put_op),
    .take_data  (take_data),
    .irq        (irq),
    .host_rdata (host_rdata)
  );

  ira_inbuf #(.CONSUME_CYC(CONSUME_CYC)) u_inbuf (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .put_data   (put_data),
    .put_op     (put_op),
    .wdata      (host_wdata),
    .in_busy    (in_busy),
    .held_byte  (held_byte),
    .held_is_op (held_is_op),
    .consume    (consume)
  );

  ira_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .consume    (consume),
    .held_byte  (held_byte),
    .held_is_op (held_is_op),
    .take_data  (take_data),
    .reg_rdata  (reg_rdata),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .out_rdy    (out_rdy),
    .out_byte   (out_byte)
  );

  // R1: nothing is strobed or pending while reset is held internally
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |=> (!reg_rd && !reg_wr && !out_rdy && !in_busy));

endmodule

// File: tb/test_ira_port.sv
`timescale 1ns/1ps
module test_ira_port;

  localparam int ADDR_W = 4;
  localparam int IDX_W  = 8;
  localparam int CONS   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_sel, host_wr, host_rd;
  logic [ADDR_W-1:0] host_addr;
  logic [7:0]        host_wdata, host_rdata;
  logic              irq, reg_rd, reg_wr;
  logic [IDX_W-1:0]  reg_idx;
  logic [7:0]        reg_wdata, reg_rdata;

  int n_checks = 0;
  int n_err    = 0;
  int rd_cnt   = 0;
  int wr_cnt   = 0;
  logic [7:0] last_rd_idx, last_wr_idx, last_wr_dat;

  always #5 clk = ~clk;

  ira_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CONSUME_CYC(CONS)) i_ira_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction

  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  assign reg_rdata = mem[reg_idx];
  always @(posedge clk) if (reg_wr) mem[reg_idx] <= reg_wdata;

  always @(negedge clk) begin
    if (reg_rd) begin rd_cnt++; last_rd_idx = reg_idx; end
    if (reg_wr) begin wr_cnt++; last_wr_idx = reg_idx; last_wr_dat = reg_wdata; end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0; host_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 50; k++) begin
      peek(4'h4, s);
      if (s[1] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 50; k++) begin
      peek(4'h4, s);
      if (s[0] == 1'b1) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(4'h4, v); check("R1", "status after reset", v, 8'h00);
    peek(4'h0, v); check("R1", "data port after reset", v, 8'h00);
    check("R1", "irq after reset", irq, 1'b0);
    check("R1", "strobes after reset", {reg_rd, reg_wr}, 2'b00);
  endtask

  task automatic t_busy_timing();
    logic [7:0] v;
    hw(4'h4, 8'h80);
    peek(4'h4, v); check("R2", "busy right after write", v[1], 1'b1);
    for (int k = 1; k < CONS; k++) begin
      @(negedge clk); peek(4'h4, v); check("R2", "busy while held", v[1], 1'b1);
    end
    @(negedge clk); peek(4'h4, v); check("R2", "busy cleared on time", v[1], 1'b0);
    hw(4'h4, 8'h7E); wait_idle();
  endtask

  task automatic t_load();
    logic [7:0] v;
    hw(4'h4, 8'h80); wait_idle();
    hw(4'h0, 8'h13);
    repeat (CONS) @(negedge clk);
    check("R4", "read strobe", reg_rd, 1'b1);
    check("R4", "read index", reg_idx, 8'h13);
    @(negedge clk);
    check("R4", "read strobe single", reg_rd, 1'b0);
    peek(4'h4, v); check("R4", "output ready", v[0], 1'b1);
    peek(4'h0, v); check("R4", "read value", v, init_val(8'h13));
    hr(4'h0, v); check("R5", "read returns value", v, init_val(8'h13));
    peek(4'h4, v); check("R5", "output ready cleared", v[0], 1'b0);
  endtask

  task automatic t_store();
    logic [7:0] v;
    int w0;
    w0 = wr_cnt;
    hw(4'h4, 8'h81); hw(4'h0, 8'h11);
    peek(4'h4, v); check("R3", "op flag kept after dropped write", v[3], 1'b1);
    wait_idle();
    hw(4'h0, 8'h20); wait_idle();
    hw(4'h0, 8'h77);
    repeat (CONS) @(negedge clk);
    check("R6", "write strobe", reg_wr, 1'b1);
    repeat (3) @(negedge clk);
    check("R6", "one write", wr_cnt - w0, 1);
    check("R3", "dropped byte not used as index", last_wr_idx, 8'h20);
    check("R6", "write value", last_wr_dat, 8'h77);
    hw(4'h4, 8'h80); wait_idle(); hw(4'h0, 8'h20); wait_ready();
    hr(4'h0, v); check("R6", "stored value reads back", v, 8'h77);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    hw(4'h4, 8'h81); wait_idle();
    hw(4'h0, 8'h30); wait_idle();
    hw(4'h4, 8'h80); wait_idle();
    hw(4'h0, 8'h40); wait_ready();
    repeat (2) @(negedge clk);
    check("R7", "abandoned store wrote nothing", wr_cnt - w0, 0);
    check("R7", "one read", rd_cnt - r0, 1);
    check("R7", "read index", last_rd_idx, 8'h40);
    hr(4'h0, v); check("R7", "read value", v, init_val(8'h40));
  endtask

  task automatic t_op_flag();
    logic [7:0] v;
    hw(4'h4, 8'h80);
    peek(4'h4, v); check("R8", "status after opcode", v, 8'h0A);
    wait_idle();
    peek(4'h4, v); check("R8", "op flag after consume", v, 8'h08);
    hw(4'h0, 8'h05);
    peek(4'h4, v); check("R8", "op flag cleared by data", v[3], 1'b0);
    wait_ready(); hr(4'h0, v); check("R8", "read after flag test", v, init_val(5));
  endtask

  task automatic t_ignored();
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    hw(4'h0, 8'h12); wait_idle();
    hw(4'h0, 8'h34); wait_idle();
    hw(4'h4, 8'h7E); wait_idle();
    hw(4'h0, 8'h10); wait_idle();
    hw(4'h0, 8'h99); wait_idle();
    repeat (3) @(negedge clk);
    check("R9", "no read strobe", rd_cnt - r0, 0);
    check("R9", "no write strobe", wr_cnt - w0, 0);
    check("R9", "index slot untouched", mem[8'h10], init_val(8'h10));
  endtask

  task automatic t_irq();
    logic [7:0] v;
    hw(4'h8, 8'h00);
    hw(4'h4, 8'h80); wait_idle(); hw(4'h0, 8'h22); wait_ready();
    check("R10", "irq masked", irq, 1'b0);
    hw(4'h8, 8'h01);
    peek(4'h8, v); check("R10", "control readback", v, 8'h01);
    check("R10", "irq enabled with output ready", irq, 1'b1);
    hr(4'h0, v);
    check("R10", "irq drops after read", irq, 1'b0);
  endtask

  task automatic t_exclusive();
    logic [7:0] v;
    int bad;
    bad = 0;
    fork
      begin
        hw(4'h4, 8'h81); wait_idle(); hw(4'h0, 8'h50); wait_idle(); hw(4'h0, 8'h51);
        wait_idle(); hw(4'h4, 8'h80); wait_idle(); hw(4'h0, 8'h50); wait_ready();
      end
      begin
        repeat (30) begin @(negedge clk); if (reg_rd && reg_wr) bad++; end
      end
    join
    check("R11", "strobes overlap count", bad, 0);
    hr(4'h0, v); check("R11", "value after mixed sequence", v, 8'h51);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    peek(4'h4, v); check("R1", "status after release", v, 8'h00);
    t_busy_timing();
    t_load();
    t_store();
    t_restart();
    t_op_flag();
    t_ignored();
    t_irq();
    t_exclusive();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule